// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits between a memory scheduler and a four-bank SDRAM command port. The scheduler offers one command per cycle with a bank number. The guard compares that command against per-bank and cross-bank spacing timers, all kept in clock cycles. It answers with a ready signal. A command goes out only in a cycle where ready is high, unless the scheduler forces it through. A forced command that breaks a spacing rule raises a violation flag.

The guard also tracks which banks hold an open row. It reports protocol errors, such as a column access to a closed bank or an activate to a bank that is already open. It marks the cycle in which read data is due, using the programmed CAS latency. The timer values come from nanosecond limits, rounded up at a 10 ns clock. The write-recovery and write-to-activate windows are counted from a last-write-beat pulse that the data path sends.

Top module: `sdram_bank_guard`

## Requirements
- R1: After ACTIVE to bank b, READ or WRITE to bank b is not ready until 2 cycles after the ACTIVE.
- R2: After ACTIVE to bank b, PRECHARGE to bank b, and PRECHARGE ALL while b is open, are not ready until 5 cycles after the ACTIVE.
- R3: ACTIVE to bank b is not ready until 7 cycles after the previous ACTIVE to b, and not until 2 cycles after a PRECHARGE that closed b.
- R4: ACTIVE to any bank is not ready until 2 cycles after an ACTIVE to a different bank.
- R5: Column commands never hold back other column commands: READ or WRITE to an open bank whose activate delay has elapsed is ready in every cycle, including the cycle right after another column command.
- R6: A last-write-beat pulse (`wr_last` high with `wr_bank`) blocks PRECHARGE to that bank in the same cycle and for the next cycle. PRECHARGE becomes ready 2 cycles after the pulse.
- R7: After a last-write-beat pulse on bank b, ACTIVE to b and AUTO REFRESH are not ready until 5 cycles after the pulse.
- R8: AUTO REFRESH is ready only when every bank's precharge and write-to-activate timers have expired. After an accepted AUTO REFRESH, both ACTIVE and another AUTO REFRESH wait 7 cycles.
- R9: Command codes on `cmd_op` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE ALL, 6 AUTO REFRESH, and code 7 behaves as NOP. NOP is always ready. A command is accepted when `cmd_valid` is high and either `cmd_ready` or `cmd_force` is high. `cmd_stall` is `cmd_valid` with `cmd_ready` low. An accepted command that was not ready sets `timing_viol` for the next cycle only.
- R10: The following accepted commands are protocol errors: READ or WRITE to a closed bank, ACTIVE to an open bank, and AUTO REFRESH while any bank is open. Each one sets `proto_err` for the next cycle only. It changes no bank state, starts no timer and produces no read-data mark.
- R11: `bank_open` bit i goes high in the cycle after an accepted ACTIVE to bank i. It goes low in the cycle after an accepted PRECHARGE to bank i or PRECHARGE ALL.
- R12: For a READ accepted in cycle c, `rd_due` is high in cycle c+2 only when `cl_sel` is 0, and in cycle c+3 only when `cl_sel` is 1. `cl_sel` is held steady while reads are in flight.
- R13: After reset, all banks are closed, all timers are expired, and `timing_viol`, `proto_err` and `rd_due` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command code (see R9) |
| cmd_bank | input | 2 | Target bank |
| cmd_force | input | 1 | Issue the command even when it is not ready |
| cl_sel | input | 1 | CAS latency select: 0 for 2 cycles, 1 for 3 cycles |
| wr_last | input | 1 | Last write data beat on the bus this cycle |
| wr_bank | input | 2 | Bank of that last write beat |
| cmd_ready | output | 1 | The offered command meets all spacing rules |
| cmd_stall | output | 1 | The offered command is valid but held back |
| timing_viol | output | 1 | A forced command broke a spacing rule in the previous cycle |
| proto_err | output | 1 | The previous accepted command was a protocol error |
| bank_open | output | 4 | One bit per bank with an open row |
| rd_due | output | 1 | Read data is expected on the bus this cycle |

## Verification
`cmd_ready` and `cmd_stall` are combinational. The bench therefore sweeps the gap between a starting command and a probed one, one cycle at a time. It reads ready in the probed cycle with valid held low, so the probe itself changes nothing. It expects ready exactly when the gap reaches the rule's cycle count. `timing_viol`, `proto_err` and `bank_open` are registered. They are sampled at the falling edge of the cycle after acceptance, and the flags are checked low again one cycle later. `rd_due` is checked in every cycle from c+1 to c+3 or c+4, so a mark one cycle early or late is caught.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_RSV  = 3'd7
  } sbg_op_e;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold a load value of cycles-1.
  function automatic int unsigned cnt_width(input int unsigned max_cyc);
    return (max_cyc > 2) ? $clog2(max_cyc) : 1;
  endfunction

endpackage

// File: rtl/sbg_down_timer.sv
module sbg_down_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sbg_bank_slice.sv
module sbg_bank_slice #(
  parameter int W   = 3,
  parameter int RCD = 2,
  parameter int RAS = 5,
  parameter int RC  = 7,
  parameter int RP  = 2,
  parameter int WR  = 2,
  parameter int DAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic pre_hit,
  input  logic wr_hit,
  output logic open_q,
  output logic col_ok,
  output logic pre_ok,
  output logic act_ok,
  output logic ref_ok
);

  localparam logic [W-1:0] L_RCD = W'((RCD > 0) ? RCD - 1 : 0);
  localparam logic [W-1:0] L_RAS = W'((RAS > 0) ? RAS - 1 : 0);
  localparam logic [W-1:0] L_RC  = W'((RC  > 0) ? RC  - 1 : 0);
  localparam logic [W-1:0] L_RP  = W'((RP  > 0) ? RP  - 1 : 0);
  localparam logic [W-1:0] L_WR  = W'((WR  > 0) ? WR  - 1 : 0);
  localparam logic [W-1:0] L_DAL = W'((DAL > 0) ? DAL - 1 : 0);

  logic rcd_ok, ras_ok, rc_ok, rp_ok, wr_ok, dal_ok;
  logic close_ev;

  assign close_ev = pre_hit && open_q;

  sbg_down_timer #(.W(W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_hit),  .load_val(L_RCD), .expired(rcd_ok));
  sbg_down_timer #(.W(W)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_hit),  .load_val(L_RAS), .expired(ras_ok));
  sbg_down_timer #(.W(W)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_hit),  .load_val(L_RC),  .expired(rc_ok));
  sbg_down_timer #(.W(W)) u_rp  (.clk(clk), .rst_n(rst_n), .load(close_ev), .load_val(L_RP),  .expired(rp_ok));
  sbg_down_timer #(.W(W)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_hit),   .load_val(L_WR),  .expired(wr_ok));
  sbg_down_timer #(.W(W)) u_dal (.clk(clk), .rst_n(rst_n), .load(wr_hit),   .load_val(L_DAL), .expired(dal_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (act_hit) open_q <= 1'b1;
    else if (pre_hit) open_q <= 1'b0;
  end

  assign col_ok = rcd_ok;
  assign pre_ok = ras_ok && wr_ok;
  assign act_ok = rp_ok && rc_ok && dal_ok;
  assign ref_ok = rp_ok && dal_ok;

  assert_open_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> open_q);
  assert_open_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && !act_hit) |=> !open_q);

  if (RCD > 1) begin : g_chk_rcd
    assert_rcd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |=> !col_ok);
  end
  if (RAS > 1) begin : g_chk_ras
    assert_ras_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |=> !pre_ok);
  end
  if (DAL > 1) begin : g_chk_dal
    assert_dal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (!act_ok && !ref_ok));
  end

endmodule

// File: rtl/sbg_read_pipe.sv
module sbg_read_pipe #(
  parameter int CL_LO = 2,
  parameter int CL_HI = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic cl_hi,
  output logic rd_due
);

  logic [CL_HI-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[CL_HI-2:0], rd_go};
  end

  assign rd_due = cl_hi ? sh_q[CL_HI-1] : sh_q[CL_LO-1];

  assert_due_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due |-> (cl_hi ? $past(rd_go, CL_HI) : $past(rd_go, CL_LO)));

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sbg_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int CLK_NS    = 10,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAS_NS  = 45,
  parameter int T_RC_NS   = 70,
  parameter int T_RP_NS   = 20,
  parameter int T_RRD_NS  = 16,
  parameter int T_RFC_NS  = 70,
  parameter int T_WR_CYC  = 2,
  parameter int T_DAL_CYC = 5,
  parameter int CL_LO     = 2,
  parameter int CL_HI     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic            cmd_force,
  input  logic            cl_sel,
  input  logic            wr_last,
  input  logic [BA_W-1:0] wr_bank,
  output logic            cmd_ready,
  output logic            cmd_stall,
  output logic            timing_viol,
  output logic            proto_err,
  output logic [(1<<BA_W)-1:0] bank_open,
  output logic            rd_due
);

  localparam int BANKS  = 1 << BA_W;
  localparam int RCD_C  = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int RAS_C  = ns_to_cyc(T_RAS_NS, CLK_NS);
  localparam int RC_C   = ns_to_cyc(T_RC_NS,  CLK_NS);
  localparam int RP_C   = ns_to_cyc(T_RP_NS,  CLK_NS);
  localparam int RRD_C  = ns_to_cyc(T_RRD_NS, CLK_NS);
  localparam int RFC_C  = ns_to_cyc(T_RFC_NS, CLK_NS);
  localparam int MAX_C  = max2(max2(max2(RCD_C, RAS_C), max2(RC_C, RP_C)),
                               max2(max2(RRD_C, RFC_C), max2(T_WR_CYC, T_DAL_CYC)));
  localparam int CW     = cnt_width(MAX_C);
  localparam logic [CW-1:0] L_RRD = CW'((RRD_C > 0) ? RRD_C - 1 : 0);
  localparam logic [CW-1:0] L_RFC = CW'((RFC_C > 0) ? RFC_C - 1 : 0);

  sbg_op_e op;
  assign op = sbg_op_e'(cmd_op);

  // Per-bank views brought out as named wires.
  logic [BANKS-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v, ref_ok_v;
  logic [BANKS-1:0] wr_blk_v, act_hit_v, pre_hit_v;

  // Cross-bank state.
  logic rrd_ok, rfc_ok;

  // Decoded events.
  logic timing_ok, proto_bad, accept, apply;
  logic act_go, rd_go, ref_go, pre_go, prea_go;

  assign act_go  = apply && (op == OP_ACT);
  assign rd_go   = apply && (op == OP_RD);
  assign ref_go  = apply && (op == OP_REF);
  assign pre_go  = apply && (op == OP_PRE);
  assign prea_go = apply && (op == OP_PREA);

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic sel;
    assign sel          = (cmd_bank == BA_W'(i));
    assign act_hit_v[i] = act_go && sel;
    assign pre_hit_v[i] = (pre_go && sel) || prea_go;
    assign wr_blk_v[i]  = wr_last && (wr_bank == BA_W'(i));

    sbg_bank_slice #(
      .W(CW), .RCD(RCD_C), .RAS(RAS_C), .RC(RC_C), .RP(RP_C),
      .WR(T_WR_CYC), .DAL(T_DAL_CYC)
    ) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_hit(act_hit_v[i]),
      .pre_hit(pre_hit_v[i]),
      .wr_hit (wr_blk_v[i]),
      .open_q (open_v[i]),
      .col_ok (col_ok_v[i]),
      .pre_ok (pre_ok_v[i]),
      .act_ok (act_ok_v[i]),
      .ref_ok (ref_ok_v[i])
    );
  end

  sbg_down_timer #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act_go), .load_val(L_RRD), .expired(rrd_ok));
  sbg_down_timer #(.W(CW)) u_rfc (.clk(clk), .rst_n(rst_n), .load(ref_go), .load_val(L_RFC), .expired(rfc_ok));

  always_comb begin
    timing_ok = 1'b1;
    proto_bad = 1'b0;
    unique case (op)
      OP_ACT: begin
        timing_ok = act_ok_v[cmd_bank] && rrd_ok && rfc_ok;
        proto_bad = open_v[cmd_bank];
      end
      OP_RD, OP_WR: begin
        timing_ok = col_ok_v[cmd_bank];
        proto_bad = !open_v[cmd_bank];
      end
      OP_PRE:  timing_ok = pre_ok_v[cmd_bank] && !wr_blk_v[cmd_bank];
      OP_PREA: timing_ok = (&(pre_ok_v | ~open_v)) && !(|(wr_blk_v & open_v));
      OP_REF: begin
        timing_ok = (&ref_ok_v) && rfc_ok;
        proto_bad = |open_v;
      end
      default: timing_ok = 1'b1;
    endcase
  end

  assign cmd_ready = timing_ok;
  assign cmd_stall = cmd_valid && !timing_ok;
  assign accept    = cmd_valid && (timing_ok || cmd_force);
  assign apply     = accept && !proto_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_viol <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      timing_viol <= accept && !timing_ok;
      proto_err   <= accept && proto_bad;
    end
  end

  sbg_read_pipe #(.CL_LO(CL_LO), .CL_HI(CL_HI)) u_rpipe (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_go (rd_go),
    .cl_hi (cl_sel),
    .rd_due(rd_due)
  );

  assign bank_open = open_v;

  assert_forced_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_force && !cmd_ready) |=> timing_viol);
  assert_viol_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timing_viol |-> $past(cmd_valid && cmd_force));
  assert_proto_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cmd_valid));
  if (RRD_C > 1) begin : g_chk_rrd
    assert_rrd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_go |=> !rrd_ok);
  end
  if (RFC_C > 1) begin : g_chk_rfc
    assert_rfc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_go |=> !rfc_ok);
  end

endmodule

// File: tb/sdram_bank_guard_tb_top.sv
module sdram_bank_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PREA = 3'd5, C_REF = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic cmd_force = 1'b0;
  logic cl_sel = 1'b0;
  logic wr_last = 1'b0;
  logic [1:0] wr_bank = 2'd0;
  logic cmd_ready, cmd_stall, timing_viol, proto_err, rd_due;
  logic [3:0] bank_open;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_force(cmd_force), .cl_sel(cl_sel),
    .wr_last(wr_last), .wr_bank(wr_bank), .cmd_ready(cmd_ready),
    .cmd_stall(cmd_stall), .timing_viol(timing_viol), .proto_err(proto_err),
    .bank_open(bank_open), .rd_due(rd_due)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; cmd_force = 1'b0; cmd_op = C_NOP; wr_last = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] bk, input logic frc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk; cmd_force = frc;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_force = 1'b0; cmd_op = C_NOP;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe(input logic [2:0] op, input logic [1:0] bk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = op; cmd_bank = bk;
    #1;
  endtask

  // Probe in the cycles at gaps 1..maxg after the last accepted command.
  task automatic sweep(input string tag, input logic [2:0] op, input logic [1:0] bk,
                       input int need, input int maxg);
    for (int g = 1; g <= maxg; g++) begin
      probe(op, bk);
      chk(tag, cmd_ready, (g >= need));
    end
  endtask

  task automatic beat(input logic [1:0] bk, input logic probe_pre);
    @(negedge clk);
    wr_last = 1'b1; wr_bank = bk;
    cmd_valid = 1'b0; cmd_op = C_PRE; cmd_bank = bk;
    #1;
    if (probe_pre) chk("R6 same-cycle beat blocks PRE", cmd_ready, 1'b0);
    @(posedge clk); #1;
    wr_last = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    // R13 reset state
    do_reset();
    @(negedge clk);
    chk("R13 bank_open", bank_open, 4'b0000);
    chk("R13 timing_viol", timing_viol, 1'b0);
    chk("R13 proto_err", proto_err, 1'b0);
    chk("R13 rd_due", rd_due, 1'b0);
    probe(C_ACT, 2'd0); chk("R13 ACT ready", cmd_ready, 1'b1);
    probe(C_REF, 2'd0); chk("R13 REF ready", cmd_ready, 1'b1);
    probe(C_PRE, 2'd3); chk("R13 PRE ready", cmd_ready, 1'b1);
    probe(C_NOP, 2'd1); chk("R9 NOP ready", cmd_ready, 1'b1);

    for (int b = 0; b < 4; b++) begin
      // R1 activate-to-column
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R1 ACT->RD", C_RD, 2'(b), 2, 4);
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R1 ACT->WR", C_WR, 2'(b), 2, 4);
      // R2 activate-to-precharge
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R2 ACT->PRE", C_PRE, 2'(b), 5, 7);
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R2 ACT->PREA", C_PREA, 2'(b), 5, 7);
      // R3 same-bank activate spacing
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R3 ACT->ACT same", C_ACT, 2'(b), 7, 9);
      do_reset(); issue(C_ACT, 2'(b), 1'b0); wait_cycles(4); issue(C_PRE, 2'(b), 1'b0);
      sweep("R3 PRE->ACT", C_ACT, 2'(b), 2, 4);
      // R4 cross-bank activate spacing
      do_reset(); issue(C_ACT, 2'(b), 1'b0); sweep("R4 ACT->ACT other", C_ACT, 2'((b + 1) % 4), 2, 3);
    end

    // R5 back-to-back column commands
    do_reset(); issue(C_ACT, 2'd0, 1'b0); wait_cycles(1); issue(C_RD, 2'd0, 1'b0);
    sweep("R5 RD->RD", C_RD, 2'd0, 1, 2);
    issue(C_WR, 2'd0, 1'b0);
    sweep("R5 WR->WR", C_WR, 2'd0, 1, 1);

    // R6 write recovery before precharge
    do_reset(); issue(C_ACT, 2'd1, 1'b0); wait_cycles(1); issue(C_WR, 2'd1, 1'b0);
    wait_cycles(3); beat(2'd1, 1'b1);
    sweep("R6 beat->PRE", C_PRE, 2'd1, 2, 3);

    // R7 data-in to activate / refresh
    do_reset(); issue(C_ACT, 2'd2, 1'b0); wait_cycles(1); issue(C_WR, 2'd2, 1'b0);
    wait_cycles(3); beat(2'd2, 1'b0); wait_cycles(1); issue(C_PRE, 2'd2, 1'b0);
    sweep("R7 beat->ACT", C_ACT, 2'd2, 3, 5);
    do_reset(); issue(C_ACT, 2'd2, 1'b0); wait_cycles(1); issue(C_WR, 2'd2, 1'b0);
    wait_cycles(3); beat(2'd2, 1'b0); wait_cycles(1); issue(C_PRE, 2'd2, 1'b0);
    sweep("R7 beat->REF", C_REF, 2'd2, 3, 5);

    // R8 refresh spacing
    do_reset(); issue(C_REF, 2'd0, 1'b0); sweep("R8 REF->ACT", C_ACT, 2'd0, 7, 9);
    do_reset(); issue(C_REF, 2'd0, 1'b0); sweep("R8 REF->REF", C_REF, 2'd0, 7, 9);
    do_reset(); issue(C_ACT, 2'd3, 1'b0); wait_cycles(10);
    probe(C_REF, 2'd0); chk("R8 REF timing with bank open", cmd_ready, 1'b1);
    issue(C_REF, 2'd0, 1'b0);
    @(negedge clk);
    chk("R10 REF with open bank", proto_err, 1'b1);
    chk("R10 REF leaves banks", bank_open, 4'b1000);

    // R9 stall and hold, R12 CL=2
    do_reset(); cl_sel = 1'b0; issue(C_ACT, 2'd0, 1'b0);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = C_RD; cmd_bank = 2'd0; #1;
    chk("R9 stall while early", cmd_stall, 1'b1);
    chk("R1 ready low at gap 1", cmd_ready, 1'b0);
    @(negedge clk); #1;
    chk("R9 stall clears", cmd_stall, 1'b0);
    chk("R1 ready at gap 2", cmd_ready, 1'b1);
    @(posedge clk); #1; cmd_valid = 1'b0; cmd_op = C_NOP;
    @(negedge clk); chk("R12 CL2 c+1", rd_due, 1'b0); chk("R9 no viol when ready", timing_viol, 1'b0);
    @(negedge clk); chk("R12 CL2 c+2", rd_due, 1'b1);
    @(negedge clk); chk("R12 CL2 c+3", rd_due, 1'b0);

    // R12 CL=3
    do_reset(); cl_sel = 1'b1; issue(C_ACT, 2'd0, 1'b0); wait_cycles(1); issue(C_RD, 2'd0, 1'b0);
    @(negedge clk); chk("R12 CL3 c+1", rd_due, 1'b0);
    @(negedge clk); chk("R12 CL3 c+2", rd_due, 1'b0);
    @(negedge clk); chk("R12 CL3 c+3", rd_due, 1'b1);
    @(negedge clk); chk("R12 CL3 c+4", rd_due, 1'b0);
    cl_sel = 1'b0;

    // R9 forced early command
    do_reset(); issue(C_ACT, 2'd1, 1'b0); issue(C_RD, 2'd1, 1'b1);
    @(negedge clk);
    chk("R9 forced early flags", timing_viol, 1'b1);
    chk("R9 forced no proto", proto_err, 1'b0);
    @(negedge clk);
    chk("R9 flag one cycle", timing_viol, 1'b0);
    chk("R12 forced read due", rd_due, 1'b1);

    // R10 protocol errors
    do_reset(); issue(C_RD, 2'd2, 1'b0);
    @(negedge clk);
    chk("R10 RD closed bank", proto_err, 1'b1);
    chk("R10 no viol", timing_viol, 1'b0);
    @(negedge clk);
    chk("R10 flag one cycle", proto_err, 1'b0);
    chk("R10 no read mark", rd_due, 1'b0);
    @(negedge clk);
    chk("R10 no read mark late", rd_due, 1'b0);
    issue(C_ACT, 2'd0, 1'b0); wait_cycles(8); issue(C_ACT, 2'd0, 1'b0);
    probe(C_PRE, 2'd0);
    chk("R10 ACT open bank", proto_err, 1'b1);
    chk("R10 ACT open no timer restart", cmd_ready, 1'b1);
    chk("R10 bank stays open", bank_open, 4'b0001);

    // R11 open-bank tracking
    do_reset(); issue(C_ACT, 2'd1, 1'b0); wait_cycles(1); issue(C_ACT, 2'd3, 1'b0);
    @(negedge clk); chk("R11 two open", bank_open, 4'b1010);
    wait_cycles(6); issue(C_PREA, 2'd0, 1'b0);
    @(negedge clk); chk("R11 PREA closes all", bank_open, 4'b0000);
    issue(C_ACT, 2'd2, 1'b0);
    @(negedge clk); chk("R11 single open", bank_open, 4'b0100);
    wait_cycles(6); issue(C_PRE, 2'd2, 1'b0);
    @(negedge clk); chk("R11 PRE closes", bank_open, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule